// File: doc/BRIEF.md
# Unlock-Sequence Flash Bank Erase and Program Sequencer

This block takes charge of a byte-wide flash part that only accepts commands after a two-write unlock handshake at fixed offsets. On a start pulse it either erases one bank or programs every byte of it from a byte source. Each command byte is written to an address built from the selected bank index and an offset inside the bank. A programmable idle gap follows every bus write.

Completion of each erase or byte program is found by reading the bank base twice in a row. While the part is busy, consecutive reads differ, and the operation counts as finished when the two reads are equal. A bounded number of such read pairs is allowed before the block gives up. Whatever the outcome, the block then writes the read-mode command to the bank base and reads the whole bank back. It compares each byte against the erased value, or against the source byte for a program operation.

A host drives `start` with `op` and `bank`, waits for the one-cycle `done` pulse, and then reads `error` and `timeout`. Both flags stay valid until the next accepted start.

Top module: `ufs_seq`

## Requirements
- R1: Out of reset the block is idle. `busy`, `done`, `error`, `timeout`, `fl_we` and `fl_re` are all low, and no bus access occurs while `busy` is low.
- R2: With `op`=0 (erase), the block issues these writes in order, as offset/data pairs: 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, 0x000/0x30.
- R3: With `op`=1 (program), the block handles offsets 0 up to the last one in ascending order. For each offset it writes 0x555/0xAA, 0x2AA/0x55, 0x555/0xA0, then the source byte to that offset, and then polls before the next offset.
- R4: After every bus write there are at least `DLY_CYC` clock cycles with no bus read or write.
- R5: Polling reads offset 0 twice on consecutive cycles, and read data arrives one cycle after `fl_re`. The operation is complete when the two values are equal.
- R6: After `POLL_MAX` unequal read pairs in one poll, `timeout` is set. During programming this also abandons the remaining bytes. If the final allowed pair is equal, that counts as completion and not as a timeout.
- R7: Every operation, including one that timed out, ends with a write of 0xF0 to offset 0 before verification.
- R8: Verification reads every offset of the bank in ascending order. It expects 0xFF after erase and `src_data` for `src_addr` after program. The first mismatch sets `error` and ends the operation.
- R9: `done` is high for exactly one cycle, and `busy` is already low in that cycle. `error` and `timeout` are cleared when a start is accepted and held from the end of the operation until the next start.
- R10: A `start` that arrives while `busy` is high is ignored and does not change the bus sequence.
- R11: Every bus address is the selected bank index in the upper `BANK_W` bits, concatenated with the offset in the lower `BANK_AW` bits. A bank captured at start stays fixed for the whole operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op | input | 1 | 0 = erase bank, 1 = program bank |
| bank | input | BANK_W | Bank index to operate on |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Verify mismatch seen in the last operation |
| timeout | output | 1 | Poll budget exhausted in the last operation |
| fl_addr | output | BANK_W+BANK_AW | Flash byte address |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | 8 | Flash read data, valid the cycle after `fl_re` |
| src_addr | output | BANK_AW | Offset whose program data is wanted |
| src_data | input | 8 | Program byte for `src_addr`, valid in the same cycle |

## Verification
Two outcomes can land on the same poll comparison. On the last permitted read pair, the data may settle just as the poll budget runs out, and completion must win over timeout. The flash model makes the part look busy for a programmable number of reads. Setting that count to exactly two reads fewer than twice the budget makes the final allowed pair the first equal one, and that run must end with `timeout` low. Setting the count to twice the budget must end with `timeout` high, and the read-mode write must still appear.

// File: rtl/ufs_pkg.sv
package ufs_pkg;

    localparam int OFF_W = 11;

    localparam logic [OFF_W-1:0] OFF_KEY1 = 11'h555;
    localparam logic [OFF_W-1:0] OFF_KEY2 = 11'h2AA;
    localparam logic [OFF_W-1:0] OFF_BASE = 11'h000;

    localparam logic [7:0] D_KEY1      = 8'hAA;
    localparam logic [7:0] D_KEY2      = 8'h55;
    localparam logic [7:0] D_ERASE_ARM = 8'h80;
    localparam logic [7:0] D_ERASE_GO  = 8'h30;
    localparam logic [7:0] D_PROG_ARM  = 8'hA0;
    localparam logic [7:0] D_READ_MODE = 8'hF0;
    localparam logic [7:0] D_BLANK     = 8'hFF;

    typedef enum logic {
        OP_ERASE = 1'b0,
        OP_PROG  = 1'b1
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_CGAP,
        ST_POLL1,
        ST_POLL2,
        ST_PCMP,
        ST_RST,
        ST_RGAP,
        ST_VRD,
        ST_VCMP
    } st_e;

    // One entry of a command script: where to write, what, and whether
    // the write goes to the byte being programmed instead of a fixed offset.
    typedef struct packed {
        logic [OFF_W-1:0] off;
        logic [7:0]       data;
        logic             to_target;
        logic             last;
    } cmd_t;

    function automatic cmd_t cmd_at(op_e op, logic [2:0] step);
        cmd_t c;
        c.off       = OFF_KEY1;
        c.data      = D_KEY1;
        c.to_target = 1'b0;
        c.last      = 1'b0;
        case (step)
            3'd0: begin
                c.off  = OFF_KEY1;
                c.data = D_KEY1;
            end
            3'd1: begin
                c.off  = OFF_KEY2;
                c.data = D_KEY2;
            end
            3'd2: begin
                c.off  = OFF_KEY1;
                c.data = (op == OP_ERASE) ? D_ERASE_ARM : D_PROG_ARM;
            end
            3'd3: begin
                if (op == OP_PROG) begin
                    c.to_target = 1'b1;
                    c.last      = 1'b1;
                end else begin
                    c.off  = OFF_KEY1;
                    c.data = D_KEY1;
                end
            end
            3'd4: begin
                c.off  = OFF_KEY2;
                c.data = D_KEY2;
            end
            default: begin
                c.off  = OFF_BASE;
                c.data = D_ERASE_GO;
                c.last = 1'b1;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ufs_delay.sv
module ufs_delay #(
    parameter int DLY = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int CW = (DLY < 2) ? 1 : $clog2(DLY + 1);
    localparam logic [CW-1:0] START_VAL = CW'(DLY - 1);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= START_VAL;
        end else if (cnt != '0) begin
            cnt <= cnt - ONE;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/ufs_poll.sv
module ufs_poll #(
    parameter int LIMIT = 1000000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       cap,
    input  logic       cmp,
    input  logic [7:0] rdata,
    output logic       settled,
    output logic       exhausted
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] FINAL = CW'(LIMIT - 1);
    localparam logic [CW-1:0] ONE   = CW'(1);

    logic [7:0]    first_q;
    logic [CW-1:0] fails_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q <= '0;
            fails_q <= '0;
        end else begin
            if (cap) begin
                first_q <= rdata;
            end
            if (clr) begin
                fails_q <= '0;
            end else if (cmp && !settled) begin
                fails_q <= fails_q + ONE;
            end
        end
    end

    assign settled   = ((first_q ^ rdata) == 8'h00);
    assign exhausted = (fails_q == FINAL);
endmodule

// File: rtl/ufs_seq.sv
module ufs_seq
    import ufs_pkg::*;
#(
    parameter int BANK_AW  = 13,
    parameter int BANK_W   = 1,
    parameter int DLY_CYC  = 50,
    parameter int POLL_MAX = 1000000
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic                      op,
    input  logic [BANK_W-1:0]         bank,
    output logic                      busy,
    output logic                      done,
    output logic                      error,
    output logic                      timeout,
    output logic [BANK_W+BANK_AW-1:0] fl_addr,
    output logic [7:0]                fl_wdata,
    output logic                      fl_we,
    output logic                      fl_re,
    input  logic [7:0]                fl_rdata,
    output logic [BANK_AW-1:0]        src_addr,
    input  logic [7:0]                src_data
);
    localparam logic [BANK_AW-1:0] LAST_IDX = '1;
    localparam logic [BANK_AW-1:0] ONE_IDX  = BANK_AW'(1);

    st_e                 state;
    op_e                 op_q;
    logic [BANK_W-1:0]   bank_q;
    logic [2:0]          step;
    logic [BANK_AW-1:0]  idx;
    logic                err_q;
    logic                tmo_q;
    logic                done_q;

    cmd_t                cmd;
    logic [BANK_AW-1:0]  off;
    logic [7:0]          expect_byte;
    logic                gap_over;
    logic                settled;
    logic                exhausted;

    assign cmd = cmd_at(op_q, step);

    ufs_delay #(.DLY(DLY_CYC)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .load    ((state == ST_CMD) || (state == ST_RST)),
        .expired (gap_over)
    );

    ufs_poll #(.LIMIT(POLL_MAX)) u_poll (
        .clk       (clk),
        .rst       (rst),
        .clr       (state == ST_CMD),
        .cap       (state == ST_POLL2),
        .cmp       (state == ST_PCMP),
        .rdata     (fl_rdata),
        .settled   (settled),
        .exhausted (exhausted)
    );

    always_comb begin
        fl_we    = 1'b0;
        fl_re    = 1'b0;
        off      = '0;
        fl_wdata = '0;
        case (state)
            ST_CMD: begin
                fl_we    = 1'b1;
                off      = cmd.to_target ? idx : BANK_AW'(cmd.off);
                fl_wdata = cmd.to_target ? src_data : cmd.data;
            end
            ST_POLL1, ST_POLL2: begin
                fl_re = 1'b1;
            end
            ST_RST: begin
                fl_we    = 1'b1;
                fl_wdata = D_READ_MODE;
            end
            ST_VRD: begin
                fl_re = 1'b1;
                off   = idx;
            end
            default: ;
        endcase
    end

    assign fl_addr     = {bank_q, off};
    assign src_addr    = idx;
    assign expect_byte = (op_q == OP_ERASE) ? D_BLANK : src_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            op_q   <= OP_ERASE;
            bank_q <= '0;
            step   <= '0;
            idx    <= '0;
            err_q  <= 1'b0;
            tmo_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        op_q   <= op_e'(op);
                        bank_q <= bank;
                        step   <= '0;
                        idx    <= '0;
                        err_q  <= 1'b0;
                        tmo_q  <= 1'b0;
                        state  <= ST_CMD;
                    end
                end
                ST_CMD: state <= ST_CGAP;
                ST_CGAP: begin
                    if (gap_over) begin
                        if (cmd.last) begin
                            step  <= '0;
                            state <= ST_POLL1;
                        end else begin
                            step  <= step + 3'd1;
                            state <= ST_CMD;
                        end
                    end
                end
                ST_POLL1: state <= ST_POLL2;
                ST_POLL2: state <= ST_PCMP;
                ST_PCMP: begin
                    if (settled) begin
                        if ((op_q == OP_PROG) && (idx != LAST_IDX)) begin
                            idx   <= idx + ONE_IDX;
                            state <= ST_CMD;
                        end else begin
                            state <= ST_RST;
                        end
                    end else if (exhausted) begin
                        tmo_q <= 1'b1;
                        state <= ST_RST;
                    end else begin
                        state <= ST_POLL1;
                    end
                end
                ST_RST: state <= ST_RGAP;
                ST_RGAP: begin
                    if (gap_over) begin
                        idx   <= '0;
                        state <= ST_VRD;
                    end
                end
                ST_VRD: state <= ST_VCMP;
                ST_VCMP: begin
                    if (fl_rdata != expect_byte) begin
                        err_q  <= 1'b1;
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else if (idx == LAST_IDX) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        idx   <= idx + ONE_IDX;
                        state <= ST_VRD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state != ST_IDLE);
    assign done    = done_q;
    assign error   = err_q;
    assign timeout = tmo_q;
endmodule

// File: rtl/ufs_chk.sv
module ufs_chk #(
    parameter int BANK_AW = 13,
    parameter int BANK_W  = 1,
    parameter int DLY_CYC = 50
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      start,
    input logic [BANK_W-1:0]         bank,
    input logic                      busy,
    input logic                      done,
    input logic                      error,
    input logic                      timeout,
    input logic                      fl_we,
    input logic                      fl_re,
    input logic [BANK_W+BANK_AW-1:0] fl_addr
);
    logic [31:0]       since_we;
    logic              armed;
    logic [BANK_W-1:0] bank_cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_we <= '0;
            armed    <= 1'b0;
            bank_cap <= '0;
        end else begin
            if (fl_we) begin
                since_we <= '0;
                armed    <= 1'b1;
            end else if (since_we != 32'hFFFF_FFFF) begin
                since_we <= since_we + 32'd1;
            end
            if (start && !busy) begin
                bank_cap <= bank;
            end
        end
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!fl_we && !fl_re));

    a_r4_write_gap: assert property (@(posedge clk) disable iff (rst)
        (armed && (fl_we || fl_re)) |-> (since_we >= 32'(DLY_CYC)));

    a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
        !(fl_we && fl_re));

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r9_flags_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(error) && $stable(timeout)));

    a_r11_bank_fixed: assert property (@(posedge clk) disable iff (rst)
        (fl_we || fl_re) |-> (fl_addr[BANK_W+BANK_AW-1 -: BANK_W] == bank_cap));
endmodule

bind ufs_seq ufs_chk #(
    .BANK_AW (BANK_AW),
    .BANK_W  (BANK_W),
    .DLY_CYC (DLY_CYC)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .bank    (bank),
    .busy    (busy),
    .done    (done),
    .error   (error),
    .timeout (timeout),
    .fl_we   (fl_we),
    .fl_re   (fl_re),
    .fl_addr (fl_addr)
);

// File: tb/tb_ufs_seq.sv
module tb_ufs_seq;
    localparam int AW   = 11;
    localparam int BW   = 1;
    localparam int FAW  = AW + BW;
    localparam int DLY  = 2;
    localparam int PMAX = 8;
    localparam int NB   = 1 << AW;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic           op = 1'b0;
    logic [BW-1:0]  bank = '0;
    logic           busy, done, error, timeout;
    logic [FAW-1:0] fl_addr;
    logic [7:0]     fl_wdata;
    logic           fl_we, fl_re;
    logic [7:0]     fl_rdata = 8'h00;
    logic [AW-1:0]  src_addr;
    logic [7:0]     src_data;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;

    function automatic logic [7:0] pat(int i);
        return 8'(i * 7 + 3);
    endfunction

    assign src_data = pat(int'(src_addr));

    always #10 clk = ~clk;

    ufs_seq #(.BANK_AW(AW), .BANK_W(BW), .DLY_CYC(DLY), .POLL_MAX(PMAX)) dut (
        .clk(clk), .rst(rst), .start(start), .op(op), .bank(bank),
        .busy(busy), .done(done), .error(error), .timeout(timeout),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
        .fl_rdata(fl_rdata), .src_addr(src_addr), .src_data(src_data)
    );

    // Behavioural flash: unlock decoder, busy toggling, AND-programming.
    logic [7:0] fmem [0:2*NB-1];
    int  seq = 0;
    int  busy_left = 0;
    bit  tog = 1'b0;
    bit  loaded = 1'b0;
    int  erase_busy = 14;
    int  prog_busy = 1;
    bit  fault_req = 1'b0;
    int  fault_addr = 0;

    always @(posedge clk) begin
        if (rst) begin
            if (!loaded) begin
                for (int i = 0; i < NB; i++) fmem[i] = 8'(i) ^ 8'h3C;
                for (int i = NB; i < 2 * NB; i++) fmem[i] = 8'hC3;
                loaded = 1'b1;
            end
            seq = 0;
            busy_left = 0;
        end else begin
            if (fault_req) fmem[fault_addr] = 8'h00;
            if (fl_re) begin
                if (busy_left > 0) begin
                    fl_rdata <= tog ? 8'h40 : 8'h00;
                    tog = !tog;
                    busy_left--;
                end else begin
                    fl_rdata <= fmem[fl_addr];
                end
            end
            if (fl_we) begin
                if (seq != 10 && fl_wdata == 8'hF0) begin
                    seq = 0;
                    busy_left = 0;
                end else begin
                    case (seq)
                        0: seq = (fl_addr[AW-1:0] == 11'h555 && fl_wdata == 8'hAA) ? 1 : 0;
                        1: seq = (fl_addr[AW-1:0] == 11'h2AA && fl_wdata == 8'h55) ? 2 : 0;
                        2: if (fl_addr[AW-1:0] == 11'h555 && fl_wdata == 8'h80) seq = 3;
                           else if (fl_addr[AW-1:0] == 11'h555 && fl_wdata == 8'hA0) seq = 10;
                           else seq = 0;
                        3: seq = (fl_addr[AW-1:0] == 11'h555 && fl_wdata == 8'hAA) ? 4 : 0;
                        4: seq = (fl_addr[AW-1:0] == 11'h2AA && fl_wdata == 8'h55) ? 5 : 0;
                        5: begin
                            if (fl_addr[AW-1:0] == 11'h000 && fl_wdata == 8'h30) begin
                                for (int i = 0; i < NB; i++)
                                    fmem[int'(fl_addr[FAW-1]) * NB + i] = 8'hFF;
                                busy_left = erase_busy;
                            end
                            seq = 0;
                        end
                        10: begin
                            fmem[fl_addr] = fmem[fl_addr] & fl_wdata;
                            busy_left = prog_busy;
                            seq = 0;
                        end
                        default: seq = 0;
                    endcase
                end
            end
        end
    end

    // Scoreboard of expected bus writes.
    logic [FAW+7:0] exp_q [$];

    task automatic push_w(logic [BW-1:0] b, logic [AW-1:0] o, logic [7:0] d);
        exp_q.push_back({b, o, d});
    endtask

    task automatic expect_erase(logic [BW-1:0] b);
        push_w(b, 11'h555, 8'hAA); push_w(b, 11'h2AA, 8'h55);
        push_w(b, 11'h555, 8'h80); push_w(b, 11'h555, 8'hAA);
        push_w(b, 11'h2AA, 8'h55); push_w(b, 11'h000, 8'h30);
        push_w(b, 11'h000, 8'hF0);
    endtask

    task automatic expect_prog(logic [BW-1:0] b, int nbytes);
        for (int i = 0; i < nbytes; i++) begin
            push_w(b, 11'h555, 8'hAA); push_w(b, 11'h2AA, 8'h55);
            push_w(b, 11'h555, 8'hA0); push_w(b, AW'(i), pat(i));
        end
        push_w(b, 11'h000, 8'hF0);
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            cycles++;
            if (fl_we) begin
                compared++;
                if (exp_q.size() == 0) begin
                    mismatched++;
                    $display("FAIL R2/R3/R7 unexpected write actual=%0h expected=none", {fl_addr, fl_wdata});
                end else begin
                    logic [FAW+7:0] e;
                    e = exp_q.pop_front();
                    if (e != {fl_addr, fl_wdata}) begin
                        mismatched++;
                        $display("FAIL R2/R3/R7/R11 write actual=%0h expected=%0h", {fl_addr, fl_wdata}, e);
                    end
                end
            end
            if (cycles > 190000) begin
                mismatched++;
                $display("FAIL watchdog actual=%0d expected<190000 cycles", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
                $finish;
            end
        end
    end

    task automatic check(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Start an operation, optionally with a stray start while busy (R10).
    task automatic run_op(logic o, logic [BW-1:0] b, int stray_at);
        @(negedge clk);
        op = o; bank = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9 busy after start", int'(busy), 1);
        check("R9 error cleared at start", int'(error), 0);
        check("R9 timeout cleared at start", int'(timeout), 0);
        for (int k = 0; !done; k++) begin
            if (k == stray_at) begin
                op = ~o; bank = ~b; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check("R9 busy low with done", int'(busy), 0);
    endtask

    task automatic after_done(string tag);
        @(negedge clk);
        check({tag, " R9 done single cycle"}, int'(done), 0);
        check({tag, " R2/R3 all writes seen"}, exp_q.size(), 0);
    endtask

    initial begin
        int bad;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 error", int'(error), 0);
        check("R1 timeout", int'(timeout), 0);
        check("R1 strobes", int'({fl_we, fl_re}), 0);

        // Erase bank 0; busy for 14 reads -> settles on the last allowed pair (R5, R6)
        erase_busy = 14;
        expect_erase(1'b0);
        run_op(1'b0, 1'b0, -1);
        check("R6 settle on final pair no timeout", int'(timeout), 0);
        check("R8 erase verify ok", int'(error), 0);
        after_done("erase0");
        bad = 0;
        for (int i = 0; i < NB; i++) if (fmem[i] != 8'hFF) bad++;
        check("R2 bank0 blank", bad, 0);
        bad = 0;
        for (int i = NB; i < 2 * NB; i++) if (fmem[i] != 8'hC3) bad++;
        check("R11 bank1 untouched", bad, 0);

        // Program bank 0 with a stray start mid-run (R3, R10)
        prog_busy = 1;
        expect_prog(1'b0, NB);
        run_op(1'b1, 1'b0, 100);
        check("R3 program timeout", int'(timeout), 0);
        check("R8 program verify ok", int'(error), 0);
        after_done("prog0");
        bad = 0;
        for (int i = 0; i < NB; i++) if (fmem[i] != pat(i)) bad++;
        check("R3 bank0 contents", bad, 0);

        // Erase bank 1; busy 16 reads -> budget exhausted (R6, R7)
        erase_busy = 16;
        expect_erase(1'b1);
        run_op(1'b0, 1'b1, -1);
        check("R6 erase timeout", int'(timeout), 1);
        check("R7 verify after timeout passes", int'(error), 0);
        after_done("erase1");

        // Program bank 1 with one stuck byte at offset 5 (R8)
        erase_busy = 2;
        fault_addr = NB + 5;
        @(negedge clk); fault_req = 1'b1;
        @(negedge clk); fault_req = 1'b0;
        expect_prog(1'b1, NB);
        run_op(1'b1, 1'b1, -1);
        check("R8 mismatch raises error", int'(error), 1);
        check("R8 mismatch no timeout", int'(timeout), 0);
        after_done("prog1");

        // Program bank 1 with first byte never settling: loop abandoned (R6)
        prog_busy = 16;
        expect_prog(1'b1, 1);
        run_op(1'b1, 1'b1, -1);
        check("R6 program timeout", int'(timeout), 1);
        check("R8 verify after program timeout", int'(error), 1);
        after_done("progto");
        repeat (5) @(negedge clk);
        check("R9 flags held while idle", int'({error, timeout}), 3);

        // Fresh erase of bank 0 clears flags at start (R9)
        prog_busy = 1;
        erase_busy = 2;
        expect_erase(1'b0);
        run_op(1'b0, 1'b0, -1);
        check("R9 final error", int'(error), 0);
        check("R9 final timeout", int'(timeout), 0);
        after_done("erase0b");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule